// File: doc/BRIEF.md
# Snapshot-Read Match Timer

A system tick timer built around a 64-bit up-counter. The counter advances once per tick. A small divider produces the ticks: it runs through two equal half periods of `DIV+1` input clocks each, so one tick comes every `2*(DIV+1)` clocks. Software reads the counter without tearing: a latch command copies all 64 bits into a snapshot pair in one edge, and software then reads the two snapshot words at leisure. The counter halves can also be written directly, so software can load or restore a value.

Six 32-bit compare channels watch the low counter word. When a tick brings the low word to a channel's compare value, that channel's sticky status bit sets and stays set until software writes 1 to it. One level interrupt line is the OR of the status bits whose enables are set. The last channel doubles as a watchdog: with the watchdog enable set, its match also drives a one-clock reset request.

The divider is a two-state machine. `PS_FIRST` (first half period) moves to `PS_SECOND` when its count reaches `DIV`. `PS_SECOND` moves back to `PS_FIRST` when its count reaches `DIV`, and issues the tick on that edge. A write to the divider register forces a restart into `PS_FIRST` with a zero count.

Top module: `tick_match_timer`

## Requirements
- R1: After reset every readable register reads 0, `irq` is low and `wdt_reset` is low.
- R2: The counter increments exactly once every 2*(DIV+1) clocks. A write to DIV (word 11) restarts the division, so the first increment lands on the 2*(DIV+1)-th rising edge after the write edge.
- R3: The counter is 64 bits wide, and a tick that wraps the low word carries into the high word.
- R4: Writing word 0 loads the low 32 counter bits and writing word 1 loads the high 32 bits. Reading those words returns the live counter.
- R5: A write to LATCH (word 12) with data bit 0 set copies the whole counter into the snapshot words 13 (low) and 14 (high). If a tick lands on the same edge, the snapshot holds the value before the increment. A LATCH write with bit 0 clear leaves the snapshot unchanged, and LATCH reads as 0.
- R6: Compare channel k (word 2+k) sets STATUS (word 8) bit k when a tick makes the low counter word equal its compare value. Loading the counter with that value directly sets nothing.
- R7: STATUS bits are sticky. Writing 1 to a bit clears it, and bits written 0 are left unchanged.
- R8: `irq` is high exactly while some STATUS bit k is set together with INT_EN (word 9) bit k.
- R9: When WDOG_EN (word 10) bit 0 is set and channel 5 matches, `wdt_reset` is high for exactly one clock. With the enable clear, `wdt_reset` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Level interrupt |
| wdt_reset | output | 1 | One-clock watchdog reset request |

## Verification
The divider is swept over DIV values 0 to 5. For each value, snapshots are taken one period apart and several periods apart. This separates a wrong period length from a wrong restart phase, and the snapshot taken on the tick edge itself shows whether the pre-increment value is captured. Compare values are placed on successive counts, so each step of the counter sets exactly one new status bit. The enable masks then pick out single bits, which shows whether `irq` gates per channel. A wrap from low word to high word, a direct load onto a compare value, and watchdog runs with the enable off and on cover the remaining corners.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int WORD_W  = 32;
    localparam int N_CH    = 6;
    localparam int WDOG_CH = N_CH - 1;
    localparam int ADDR_W  = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CNT_LO  = 4'd0,
        A_CNT_HI  = 4'd1,
        A_MATCH0  = 4'd2,
        A_STATUS  = 4'd8,
        A_INTEN   = 4'd9,
        A_WDEN    = 4'd10,
        A_DIV     = 4'd11,
        A_LATCH   = 4'd12,
        A_SNAP_LO = 4'd13,
        A_SNAP_HI = 4'd14
    } reg_addr_e;

    typedef enum logic {
        PS_FIRST,
        PS_SECOND
    } ps_state_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    ps_state_e        state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic             half_done;

    assign half_done = (cnt_q == div);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        if (restart) begin
            state_d = PS_FIRST;
            cnt_d   = '0;
        end else if (half_done) begin
            cnt_d = '0;
            unique case (state_q)
                PS_FIRST:  state_d = PS_SECOND;
                PS_SECOND: state_d = PS_FIRST;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_FIRST;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        tick = (state_q == PS_SECOND) && half_done;
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/tmr_match_chan.sv
module tmr_match_chan
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              match_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              clr,
    input  logic              tick,
    input  logic [WORD_W-1:0] cnt_lo_next,
    output logic [WORD_W-1:0] match_q,
    output logic              status_q,
    output logic              hit
);
    assign hit = tick && (cnt_lo_next == match_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q  <= '0;
            status_q <= 1'b0;
        end else begin
            if (match_wr) match_q <= wdata;
            if (hit)      status_q <= 1'b1;
            else if (clr) status_q <= 1'b0;
        end
    end

    // R7
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status_q) && !$past(clr)) |-> status_q);
    // R6
    status_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q) |-> $past(hit));
endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer
    import tmr_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq,
    output logic              wdt_reset
);
    localparam int CNT_W = 2 * WORD_W;

    logic              wr_en;
    logic [CNT_W-1:0]  cnt_q, cnt_inc, snap_q;
    logic [N_CH-1:0]   inten_q, status, hits;
    logic              wden_q;
    logic [DIV_W-1:0]  div_q;
    logic              tick_raw, cnt_wr, tick_eff, latch_cmd;
    logic [WORD_W-1:0] match_q [N_CH];

    assign wr_en     = bus_sel && bus_wr;
    assign cnt_wr    = wr_en && (bus_addr == A_CNT_LO || bus_addr == A_CNT_HI);
    assign tick_eff  = tick_raw && !cnt_wr;
    assign cnt_inc   = cnt_q + 1'b1;
    assign latch_cmd = wr_en && (bus_addr == A_LATCH) && bus_wdata[0];

    tmr_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_en && bus_addr == A_DIV),
        .div     (div_q),
        .tick    (tick_raw)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        localparam logic [ADDR_W-1:0] MADDR = ADDR_W'(int'(A_MATCH0) + g);
        tmr_match_chan u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .match_wr    (wr_en && bus_addr == MADDR),
            .wdata       (bus_wdata),
            .clr         (wr_en && bus_addr == A_STATUS && bus_wdata[g]),
            .tick        (tick_eff),
            .cnt_lo_next (cnt_inc[WORD_W-1:0]),
            .match_q     (match_q[g]),
            .status_q    (status[g]),
            .hit         (hits[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            snap_q    <= '0;
            inten_q   <= '0;
            wden_q    <= 1'b0;
            div_q     <= '0;
            wdt_reset <= 1'b0;
        end else begin
            if (wr_en && bus_addr == A_CNT_LO)      cnt_q[WORD_W-1:0] <= bus_wdata;
            else if (wr_en && bus_addr == A_CNT_HI) cnt_q[CNT_W-1:WORD_W] <= bus_wdata;
            else if (tick_raw)                      cnt_q <= cnt_inc;
            if (latch_cmd)                          snap_q <= cnt_q;
            if (wr_en && bus_addr == A_INTEN)       inten_q <= bus_wdata[N_CH-1:0];
            if (wr_en && bus_addr == A_WDEN)        wden_q <= bus_wdata[0];
            if (wr_en && bus_addr == A_DIV)         div_q <= bus_wdata[DIV_W-1:0];
            wdt_reset <= wden_q && hits[WDOG_CH];
        end
    end

    assign irq = |(status & inten_q);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CNT_LO:  bus_rdata = cnt_q[WORD_W-1:0];
            A_CNT_HI:  bus_rdata = cnt_q[CNT_W-1:WORD_W];
            A_STATUS:  bus_rdata = WORD_W'(status);
            A_INTEN:   bus_rdata = WORD_W'(inten_q);
            A_WDEN:    bus_rdata = WORD_W'(wden_q);
            A_DIV:     bus_rdata = WORD_W'(div_q);
            A_SNAP_LO: bus_rdata = snap_q[WORD_W-1:0];
            A_SNAP_HI: bus_rdata = snap_q[CNT_W-1:WORD_W];
            default: begin
                for (int k = 0; k < N_CH; k++)
                    if (int'(bus_addr) == int'(A_MATCH0) + k) bus_rdata = match_q[k];
            end
        endcase
    end

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_raw && !cnt_wr) |=> (cnt_q == $past(cnt_q) + 64'd1));
    // R5
    snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_cmd |=> (snap_q == $past(cnt_q)));
    // R9
    wdt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset |=> !wdt_reset);
    // R9
    wdt_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset |-> status[WDOG_CH]);
endmodule

// File: tb/test_tick_match_timer.sv
`timescale 1ns/1ps
module test_tick_match_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, wdt_reset;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    bit done = 0;

    localparam int BIG = 1000;

    always #2 clk = ~clk;

    tick_match_timer i_tick_match_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .wdt_reset(wdt_reset)
    );

    always @(negedge clk) if (rst_n && wdt_reset) pulses++;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1; d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    // exactly n ticks, then counter frozen
    task automatic advance(input int n);
        wr(4'd11, 32'd0);
        idle(2 * n);
        wr(4'd11, BIG);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL timeout actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v0;
        idle(3);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        for (int a = 0; a < 15; a++) begin
            rd(4'(a), v);
            chk($sformatf("R1 reg%0d", a), v, 0);
        end
        chk("R1 irq", irq, 0);
        chk("R1 wdt_reset", wdt_reset, 0);

        // R4 load and readback, counter frozen
        wr(4'd11, BIG);
        wr(4'd0, 32'h1234_5678);
        wr(4'd1, 32'h0000_0009);
        rd(4'd0, v); chk("R4 cnt lo", v, 32'h1234_5678);
        rd(4'd1, v); chk("R4 cnt hi", v, 32'h9);
        // R5 bit0 clear: no capture
        wr(4'd12, 32'hFFFF_FFFE);
        rd(4'd13, v); chk("R5 no latch lo", v, 0);
        wr(4'd12, 32'h1);
        rd(4'd13, v); chk("R5 snap lo", v, 32'h1234_5678);
        rd(4'd14, v); chk("R5 snap hi", v, 32'h9);
        rd(4'd12, v); chk("R5 latch reads 0", v, 0);

        // R3 carry
        wr(4'd0, 32'hFFFF_FFFE);
        wr(4'd1, 32'h5);
        advance(2);
        rd(4'd0, v); chk("R3 lo after wrap", v, 0);
        rd(4'd1, v); chk("R3 hi after wrap", v, 32'h6);

        // R2 divider sweep
        for (int d = 0; d < 6; d++) begin
            int p;
            p = 2 * (d + 1);
            wr(4'd11, d);
            wr(4'd12, 1);
            rd(4'd13, v0);
            idle(p - 2);
            wr(4'd12, 1);
            rd(4'd13, v); chk($sformatf("R5 coincident tick div=%0d", d), v, v0);
            wr(4'd12, 1);
            rd(4'd13, v); chk($sformatf("R2 first tick div=%0d", d), v, v0 + 1);
            idle(3 * p - 1);
            wr(4'd12, 1);
            rd(4'd13, v); chk($sformatf("R2 period div=%0d", d), v, v0 + 4);
        end
        wr(4'd11, BIG);

        // R6 R7 R8 matches
        wr(4'd0, 32'd100);
        wr(4'd1, 32'd0);
        for (int k = 0; k < 6; k++) wr(4'(2 + k), 32'(101 + k));
        wr(4'd8, 32'h3F);
        wr(4'd9, 32'h0);
        rd(4'd8, v); chk("R7 cleared", v, 0);
        rd(4'd4, v); chk("R6 match2 readback", v, 32'd103);
        advance(3);
        rd(4'd8, v); chk("R6 status after 3 ticks", v, 32'h07);
        chk("R8 irq masked", irq, 0);
        wr(4'd9, 32'h08);
        chk("R8 irq other bit", irq, 0);
        wr(4'd9, 32'h0C);
        chk("R8 irq enabled bit", irq, 1);
        wr(4'd8, 32'h0);
        rd(4'd8, v); chk("R7 write 0 no effect", v, 32'h07);
        wr(4'd8, 32'h04);
        rd(4'd8, v); chk("R7 w1c one bit", v, 32'h03);
        chk("R8 irq after clear", irq, 0);
        advance(3);
        rd(4'd8, v); chk("R6 status all later", v, 32'h3B);
        chk("R8 irq bit3", irq, 1);
        wr(4'd8, 32'h3F);
        wr(4'd2, 32'd500);
        wr(4'd0, 32'd500);
        rd(4'd8, v); chk("R6 direct load no match", v, 0);
        chk("R8 irq none", irq, 0);

        // R9 watchdog
        chk("R9 no pulse when disabled", pulses, 0);
        wr(4'd10, 32'h1);
        rd(4'd10, v); chk("R9 wden readback", v, 1);
        wr(4'd0, 32'd200);
        wr(4'd7, 32'd202);
        wr(4'd8, 32'h3F);
        advance(1);
        chk("R9 no pulse before match", pulses, 0);
        advance(3);
        chk("R9 single pulse", pulses, 1);
        rd(4'd8, v); chk("R9 status5 set", v[5], 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule